// File: doc/BRIEF.md
# Serial Register Access Port

This block is the slave end of a four-wire serial link that lets an outside controller read and write a byte-wide register file. A transaction is framed by an active-low select line. Each frame carries a 7-bit register index, then a direction flag, then one data byte. Every field travels most significant bit first. A flag of 1 stores the data byte into the indexed register. A flag of 0 returns that register's contents on the serial output during the byte slot, and the controller's own data bits are ignored in that case.

The serial select, clock and input lines are brought into a faster system clock through synchronizer stages. Serial clock edges are then detected in that domain. Input bits are taken on rising serial clock edges, and output bits are launched on falling ones. Inside the block, a write travels from the frame engine to the register bank as a valid/ready request. The bank accepts every request at once, so the request never stalls and each store appears as a single-cycle strobe. The serial edge has no back-pressure: the controller sets the pace, and the system clock must run at least eight times faster than the serial clock. The serial output drives a value only while read data is being returned. At all other times it floats, and a separate enable pin reports its state.

Top module: `spi_regif_top`

## Requirements
- R1: A frame consists of 7 index bits, one direction bit and 8 data bits, in that order, each field most significant bit first.
- R2: When the direction bit is 1, the 8 data bits are stored into the register at the given index. The store happens only after the 16th bit has been received.
- R3: When the direction bit is 0, the addressed register is returned on the serial output, bit 7 first. Bit 7 is driven after the first falling serial clock edge that follows the direction bit, and one further bit is driven after each later falling edge.
- R4: The serial output enable is 0, and the output is high-impedance, except during the 8 data bit slots of a read frame.
- R5: A high select returns the interface to idle and clears the bit count and the shift registers. Serial clock edges are ignored while select is high. A write frame that is cut short before its 16th bit leaves the register unchanged.
- R6: Input bits are taken at rising serial clock edges, so a change on the serial input while the serial clock is high does not affect the bit received. Output bits change only after falling edges.
- R7: After reset, all 128 registers read 0x00 and the output enable is 0.
- R8: Each accepted write produces a store strobe that lasts exactly one system clock cycle.
- R9: Serial clock pulses beyond the 16th in a frame are ignored, so the stored byte is the one carried by bits 8 to 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sel_n | input | 1 | Active-low frame select |
| spi_clk | input | 1 | Serial clock, idles low |
| spi_mosi | input | 1 | Serial data from the controller |
| spi_miso | output | 1 | Serial data to the controller, high-impedance when not enabled |
| spi_miso_oe | output | 1 | High while spi_miso is actively driven |

## Verification
A serial clock edge reaches the frame engine three system cycles after it occurs: two synchronizer stages and one edge register. A newly shifted output bit appears on the pins one cycle after that. The bench holds each serial clock phase for eight system cycles and samples the output and enable just before each rising edge. That point is at least four cycles after the most recent change is due. A committed write is checked by reading the register back in a later frame, well after the one-cycle store strobe has occurred. Idle and abort behaviour is checked several cycles after select rises.

// File: rtl/spi_regif_pkg.sv
package spi_regif_pkg;
  typedef enum logic [1:0] {
    PH_ADDR = 2'd0,
    PH_RD   = 2'd1,
    PH_WR   = 2'd2,
    PH_DONE = 2'd3
  } phase_e;

  function automatic int frame_bits(input int aw, input int dw);
    return aw + 1 + dw;
  endfunction
endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
  parameter int            STAGES  = 2,
  parameter int            WIDTH   = 3,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= RST_VAL;
      else if (s == 0) stage_q[s] <= async_i;
      else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/spi_frame.sv
module spi_frame
  import spi_regif_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ss_s,
  input  logic              sck_s,
  input  logic              si_s,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] rd_data,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              so_d,
  output logic              so_oe
);
  localparam int FRAME = frame_bits(ADDR_W, DATA_W);
  localparam int CNT_W = $clog2(FRAME + 1);
  localparam logic [CNT_W-1:0] C_FRAME = CNT_W'(FRAME);
  localparam logic [CNT_W-1:0] C_LAST  = CNT_W'(FRAME - 1);
  localparam logic [CNT_W-1:0] C_FLAG  = CNT_W'(ADDR_W);

  logic              sck_q, rise, fall;
  logic [CNT_W-1:0]  cnt;
  logic [ADDR_W-1:0] addr_sr;
  logic [DATA_W-1:0] in_sr, out_sr;
  phase_e            phase;

  assign rise    = sck_s & ~sck_q;
  assign fall    = ~sck_s & sck_q;
  assign rd_addr = addr_sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q    <= 1'b0;
      cnt      <= '0;
      addr_sr  <= '0;
      in_sr    <= '0;
      out_sr   <= '0;
      phase    <= PH_ADDR;
      wr_valid <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
      so_d     <= 1'b0;
      so_oe    <= 1'b0;
    end else begin
      sck_q <= sck_s;
      if (wr_ready) wr_valid <= 1'b0;
      if (ss_s) begin
        cnt     <= '0;
        addr_sr <= '0;
        in_sr   <= '0;
        out_sr  <= '0;
        phase   <= PH_ADDR;
        so_d    <= 1'b0;
        so_oe   <= 1'b0;
      end else begin
        if (rise && cnt < C_FRAME) begin
          cnt <= cnt + 1'b1;
          if (cnt < C_FLAG) begin
            addr_sr <= {addr_sr[ADDR_W-2:0], si_s};
          end else if (cnt == C_FLAG) begin
            phase <= si_s ? PH_WR : PH_RD;
            if (!si_s) out_sr <= rd_data;
          end else begin
            in_sr <= {in_sr[DATA_W-2:0], si_s};
          end
          if (cnt == C_LAST) begin
            if (phase == PH_WR) begin
              wr_valid <= 1'b1;
              wr_addr  <= addr_sr;
              wr_data  <= {in_sr[DATA_W-2:0], si_s};
            end
            phase <= PH_DONE;
            so_oe <= 1'b0;
          end
        end
        if (fall && phase == PH_RD) begin
          so_oe  <= 1'b1;
          so_d   <= out_sr[DATA_W-1];
          out_sr <= {out_sr[DATA_W-2:0], 1'b0};
        end
      end
    end
  end

  // R9: bit count never passes the frame length
  p_cnt_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= C_FRAME);
  // R5: a high select leaves the engine idle on the next cycle
  p_ss_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ss_s |=> (cnt == '0 && !so_oe));
  // R4: output enabled only in the read data phase
  p_oe_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    so_oe |-> phase == PH_RD);
  // R6: driven output only changes after a falling edge
  p_so_on_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (so_oe && !fall && !ss_s) |=> (!so_oe || $stable(so_d)));
  // R2: a store is raised only once the full frame is in
  p_wr_full_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_valid) |-> cnt == C_FRAME);
endmodule

// File: rtl/spi_regbank.sv
module spi_regbank #(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  assign wr_ready = 1'b1;
  assign rd_data  = mem[rd_addr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (wr_valid && wr_ready) begin
      mem[wr_addr] <= wr_data;
    end
  end

  // R2: an accepted request lands in the addressed entry
  p_commit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready) |=> mem[$past(wr_addr)] == $past(wr_data));
endmodule

// File: rtl/spi_regif_top.sv
module spi_regif_top #(
  parameter int ADDR_W      = 7,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic spi_sel_n,
  input  logic spi_clk,
  input  logic spi_mosi,
  output logic spi_miso,
  output logic spi_miso_oe
);
  logic [2:0]        sync_v;
  logic              ss_s, sck_s, si_s;
  logic [ADDR_W-1:0] rd_addr, wr_addr;
  logic [DATA_W-1:0] rd_data, wr_data;
  logic              wr_valid, wr_ready, so_d, so_oe;

  spi_sync #(.STAGES(SYNC_STAGES), .WIDTH(3), .RST_VAL(3'b100)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .async_i({spi_sel_n, spi_clk, spi_mosi}),
    .sync_o (sync_v)
  );
  assign {ss_s, sck_s, si_s} = sync_v;

  spi_frame #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_frame (
    .clk     (clk),
    .rst_n   (rst_n),
    .ss_s    (ss_s),
    .sck_s   (sck_s),
    .si_s    (si_s),
    .rd_addr (rd_addr),
    .rd_data (rd_data),
    .wr_valid(wr_valid),
    .wr_ready(wr_ready),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .so_d    (so_d),
    .so_oe   (so_oe)
  );

  spi_regbank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_valid(wr_valid),
    .wr_ready(wr_ready),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_addr (rd_addr),
    .rd_data (rd_data)
  );

  assign spi_miso_oe = so_oe;
  assign spi_miso    = so_oe ? so_d : 1'bz;

  // R8: the store strobe lasts a single cycle
  p_strobe_one_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |=> !wr_valid);
  // R4: nothing is driven while the frame is deselected
  p_no_drive_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ss_s && $past(ss_s)) |-> !spi_miso_oe);
endmodule

// File: tb/sim_spi_regif_top.sv
module sim_spi_regif_top;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sel_n = 1'b1, sck = 1'b0, mosi = 1'b0;
  logic miso, miso_oe;
  int   n_chk = 0, n_err = 0;
  bit   done = 1'b0;

  spi_regif_top u0 (
    .clk(clk), .rst_n(rst_n), .spi_sel_n(sel_n), .spi_clk(sck),
    .spi_mosi(mosi), .spi_miso(miso), .spi_miso_oe(miso_oe)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // One frame; nbits may be short (abort) or long (extra clocks).
  task automatic xfer(input logic [6:0] a, input logic rw, input logic [7:0] d,
                      input int nbits, input bit glitch,
                      output logic [7:0] q, output int oe_bad);
    logic [15:0] fr;
    fr = {a, rw, d};
    q = '0;
    oe_bad = 0;
    sel_n = 1'b0;
    cyc(HALF);
    for (int i = 0; i < nbits; i++) begin
      mosi = (i < 16) ? fr[15-i] : 1'b1;
      cyc(HALF);
      if (miso_oe !== ((rw == 1'b0) && i >= 8 && i < 16)) oe_bad++;
      if (i >= 8 && i < 16) q = {q[6:0], miso};
      sck = 1'b1;
      if (glitch) begin
        cyc(4);
        mosi = ~mosi;
        cyc(HALF - 4);
      end else cyc(HALF);
      sck = 1'b0;
    end
    cyc(HALF);
    sel_n = 1'b1;
    cyc(HALF);
    if (miso_oe !== 1'b0) oe_bad++;
  endtask

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 37 + 5) ^ (a >> 2));
  endfunction

  initial begin
    logic [7:0] q;
    int bad;
    cyc(4);
    // R7: output released in reset state
    check("R7 oe after reset", {31'd0, miso_oe}, 32'd0);
    check("R4 miso z after reset", {31'd0, miso === 1'bz}, 32'd1);
    rst_n = 1'b1;
    cyc(4);
    // R5: clock pulses while deselected are ignored
    for (int k = 0; k < 10; k++) begin
      sck = 1'b1; cyc(HALF); sck = 1'b0; cyc(HALF);
    end
    check("R5 no drive while deselected", {31'd0, miso_oe}, 32'd0);
    // R7: registers start at zero
    for (int a = 0; a < 128; a += 9) begin
      xfer(7'(a), 1'b0, 8'hFF, 16, 1'b0, q, bad);
      check("R7 reset value", {24'd0, q}, 32'd0);
      check("R4 oe window read", bad, 0);
    end
    // R1/R2: write every register
    for (int a = 0; a < 128; a++) begin
      xfer(7'(a), 1'b1, pat(a), 16, 1'b0, q, bad);
      check("R4 oe never on in write", bad, 0);
    end
    // R1/R3: read all back
    for (int a = 0; a < 128; a++) begin
      xfer(7'(a), 1'b0, ~pat(a), 16, 1'b0, q, bad);
      check("R3 read data", {24'd0, q}, {24'd0, pat(a)});
      check("R4 oe window read", bad, 0);
    end
    // R5: aborted write leaves register unchanged
    xfer(7'd5, 1'b1, 8'h3C, 12, 1'b0, q, bad);
    xfer(7'd5, 1'b0, 8'h00, 16, 1'b0, q, bad);
    check("R5 aborted write discarded", {24'd0, q}, {24'd0, pat(5)});
    xfer(7'd5, 1'b1, 8'h3C, 15, 1'b0, q, bad);
    xfer(7'd5, 1'b0, 8'h00, 16, 1'b0, q, bad);
    check("R5 write cut at bit 15 discarded", {24'd0, q}, {24'd0, pat(5)});
    // R5: aborted read releases output
    xfer(7'd6, 1'b0, 8'h00, 11, 1'b0, q, bad);
    check("R5 abort read releases miso", bad, 0);
    check("R4 miso z after abort", {31'd0, miso === 1'bz}, 32'd1);
    // R9: extra clocks ignored
    xfer(7'd9, 1'b1, 8'hA5, 21, 1'b0, q, bad);
    xfer(7'd9, 1'b0, 8'h00, 16, 1'b0, q, bad);
    check("R9 extra clocks ignored", {24'd0, q}, 32'h0000_00A5);
    // R6: input changes during high phase do not matter
    xfer(7'd77, 1'b1, 8'h96, 16, 1'b1, q, bad);
    xfer(7'd77, 1'b0, 8'h00, 16, 1'b1, q, bad);
    check("R6 rising-edge sampling", {24'd0, q}, 32'h0000_0096);
    // R2/R8: back-to-back writes to adjacent registers
    xfer(7'd127, 1'b1, 8'h01, 16, 1'b0, q, bad);
    xfer(7'd126, 1'b1, 8'h80, 16, 1'b0, q, bad);
    xfer(7'd127, 1'b0, 8'h00, 16, 1'b0, q, bad);
    check("R8 single store 127", {24'd0, q}, 32'h0000_0001);
    xfer(7'd126, 1'b0, 8'h00, 16, 1'b0, q, bad);
    check("R2 store 126", {24'd0, q}, 32'h0000_0080);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog actual=timeout expected=finish");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule